// File: doc/BRIEF.md
# Shared-Register Channel Transfer Sequencer

This block serves word transfers for a set of peripheral channels. It has one set of working registers, and every channel uses it in turn. Each channel owns one control word in a small on-chip control store. The word holds the next main-memory address, the remaining word count and a status nibble. There is no per-channel address or count register.

When a channel raises its request line, a round-robin arbiter picks it. The sequencer reads that channel's control word into the working registers and makes one main-memory access through a request/acknowledge handshake. It then advances the address, decrements the count, revises the status and writes the word back. Each transfer costs one memory cycle and needs no processor involvement.

Software-side setup uses a load port that writes a fresh control word for one channel. A channel whose count reaches zero is marked done. Its requests are then ignored until it is loaded again.

Top module: `cw_exchange`

## Requirements
- R1: After reset the sequencer is idle: `ld_ready` is 1, and `mem_req`, `svc_ack` and `done_o` are all 0.
- R2: A load (`ld_valid` while `ld_ready`) stores address `ld_addr`, count `ld_cnt` and a cleared status for channel `ld_ch`. A load with count 0 marks the channel done at once, with no transfer and no done pulse. A reload clears a previous done state.
- R3: A serviced channel produces exactly one `mem_req` access. `mem_addr` equals the channel's stored address and `mem_ch` equals the channel number. Both are held stable until `mem_ack`.
- R4: After each transfer the stored address grows by one (modulo 2^AW, so 0xFFFF wraps to 0x0000 at the default width) and the count shrinks by one. The updated word is written back, so the channel's next service uses the new address.
- R5: Each completed transfer raises exactly one `svc_ack` bit: bit number = channel number, for one clock cycle.
- R6: The transfer that brings the count to zero raises the channel's `done_o` bit for one cycle, in the same cycle as its `svc_ack` bit.
- R7: A request from a channel marked done is ignored. It causes no memory access and no `svc_ack`.
- R8: The arbiter is round-robin. After reset the search starts at channel 0. The winner is the first requesting channel at or after the search start. The start then moves to winner+1 (wrapping to 0), whether or not the winner turns out to be done.
- R9: `ld_ready` is high only while idle, and is low during any service. A load presented while idle takes precedence over starting a service in that cycle.
- R10: Only one transfer is in flight at a time. `mem_req` falls only in the cycle after `mem_ack` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NCH | Per-channel service request levels |
| ld_valid | input | 1 | Load a control word |
| ld_ch | input | CHW | Channel to load |
| ld_addr | input | AW | Start address for the load |
| ld_cnt | input | CNTW | Word count for the load |
| ld_ready | output | 1 | Sequencer idle, load accepted |
| mem_req | output | 1 | Main-memory access request |
| mem_addr | output | AW | Access address |
| mem_ch | output | CHW | Channel owning the access |
| mem_ack | input | 1 | Main-memory access acknowledge |
| svc_ack | output | NCH | One-cycle per-channel transfer pulse |
| done_o | output | NCH | One-cycle per-channel completion pulse |

## Verification
The assertions assume that the memory side raises `mem_ack` only while `mem_req` is high, and that loads are presented only when `ld_ready` is high. The stimulus honours both. The responder acknowledges only an outstanding request and drops the acknowledge one cycle later. The load task waits on a falling clock edge for `ld_ready` before it drives `ld_valid`. Requests are raised only for channels that hold a loaded control word, so the sequencer never reads an unwritten control-store entry.

// File: rtl/cwx_pkg.sv
package cwx_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH_CW,
      S_MEM_ACCESS,
      S_UPDATE,
      S_WRITEBACK
   } seq_state_t;

   // status nibble layout inside a control word
   localparam int ST_W    = 4;
   localparam int ST_DONE = 0;   // count exhausted
   localparam int ST_RUN  = 1;   // at least one transfer made since load

endpackage

// File: rtl/cwx_arb.sv
module cwx_arb #(
   parameter int NCH = 8,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] req,
   input  logic           take,
   output logic           any,
   output logic [CHW-1:0] win
);

   logic [CHW-1:0] ptr;
   int             idx;

   always_comb begin
      any = 1'b0;
      win = '0;
      idx = 0;
      for (int i = 0; i < NCH; i++) begin
         if (!any) begin
            idx = int'(ptr) + i;
            if (idx >= NCH) idx = idx - NCH;
            if (req[idx]) begin
               any = 1'b1;
               win = CHW'(idx);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (take) begin
         ptr <= (win == CHW'(NCH - 1)) ? '0 : win + 1'b1;
      end
   end

endmodule

// File: rtl/cwx_store.sv
module cwx_store #(
   parameter int DEPTH = 8,
   parameter int W     = 36,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          re,
   input  logic [IW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/cwx_seq.sv
module cwx_seq
   import cwx_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int AW   = 16,
   parameter int CNTW = 16,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int CWW = ST_W + CNTW + AW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_valid,
   input  logic [CHW-1:0]  ld_ch,
   input  logic [AW-1:0]   ld_addr,
   input  logic [CNTW-1:0] ld_cnt,
   output logic            ld_ready,
   input  logic            arb_any,
   input  logic [CHW-1:0]  arb_win,
   output logic            arb_take,
   output logic            st_re,
   output logic [CHW-1:0]  st_raddr,
   input  logic [CWW-1:0]  st_rdata,
   output logic            st_we,
   output logic [CHW-1:0]  st_waddr,
   output logic [CWW-1:0]  st_wdata,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   input  logic            mem_ack,
   output logic            ack_v,
   output logic            done_v,
   output logic [CHW-1:0]  cur_ch
);

   seq_state_t       state, nstate;
   logic [CHW-1:0]   ch_q;
   logic [ST_W-1:0]  wk_st;
   logic [CNTW-1:0]  wk_cnt;
   logic [AW-1:0]    wk_addr;
   logic             ld_go;
   logic [ST_W-1:0]  ld_st;
   logic [ST_W-1:0]  rd_st;

   assign rd_st = st_rdata[CWW-1 -: ST_W];

   always_comb begin
      ld_st = '0;
      ld_st[ST_DONE] = (ld_cnt == '0);
   end

   assign ld_ready = (state == S_IDLE);
   assign ld_go    = ld_ready && ld_valid;
   assign arb_take = ld_ready && !ld_valid && arb_any;
   assign st_re    = arb_take;
   assign st_raddr = arb_win;
   assign mem_req  = (state == S_MEM_ACCESS);
   assign mem_addr = wk_addr;
   assign ack_v    = (state == S_WRITEBACK);
   assign done_v   = ack_v && wk_st[ST_DONE];
   assign cur_ch   = ch_q;

   always_comb begin
      st_we    = 1'b0;
      st_waddr = ch_q;
      st_wdata = {wk_st, wk_cnt, wk_addr};
      if (ld_go) begin
         st_we    = 1'b1;
         st_waddr = ld_ch;
         st_wdata = {ld_st, ld_cnt, ld_addr};
      end else if (state == S_WRITEBACK) begin
         st_we    = 1'b1;
      end
   end

   always_comb begin
      nstate = state;
      unique case (state)
         S_IDLE:       if (arb_take) nstate = S_FETCH_CW;
         S_FETCH_CW:   nstate = rd_st[ST_DONE] ? S_IDLE : S_MEM_ACCESS;
         S_MEM_ACCESS: if (mem_ack) nstate = S_UPDATE;
         S_UPDATE:     nstate = S_WRITEBACK;
         S_WRITEBACK:  nstate = S_IDLE;
         default:      nstate = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         ch_q    <= '0;
         wk_st   <= '0;
         wk_cnt  <= '0;
         wk_addr <= '0;
      end else begin
         state <= nstate;
         if (arb_take) ch_q <= arb_win;
         if (state == S_FETCH_CW) begin
            {wk_st, wk_cnt, wk_addr} <= st_rdata;
         end
         if (state == S_UPDATE) begin
            wk_addr        <= wk_addr + 1'b1;
            wk_cnt         <= wk_cnt - 1'b1;
            wk_st[ST_RUN]  <= 1'b1;
            wk_st[ST_DONE] <= (wk_cnt == CNTW'(1));
         end
      end
   end

endmodule

// File: rtl/cw_exchange.sv
module cw_exchange
   import cwx_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int AW   = 16,
   parameter int CNTW = 16,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  req,
   input  logic            ld_valid,
   input  logic [CHW-1:0]  ld_ch,
   input  logic [AW-1:0]   ld_addr,
   input  logic [CNTW-1:0] ld_cnt,
   output logic            ld_ready,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   output logic [CHW-1:0]  mem_ch,
   input  logic            mem_ack,
   output logic [NCH-1:0]  svc_ack,
   output logic [NCH-1:0]  done_o
);

   localparam int CWW = ST_W + CNTW + AW;

   generate
      if (NCH < 2 || NCH > 256) begin : g_bad_nch
         $error("cw_exchange: NCH must lie in 2..256");
      end
      if (AW < 1 || CNTW < 1) begin : g_bad_w
         $error("cw_exchange: AW and CNTW must be positive");
      end
   endgenerate

   logic           arb_any, arb_take;
   logic [CHW-1:0] arb_win;
   logic           st_re, st_we;
   logic [CHW-1:0] st_raddr, st_waddr;
   logic [CWW-1:0] st_rdata, st_wdata;
   logic           ack_v, done_v;
   logic [CHW-1:0] cur_ch;

   cwx_arb #(.NCH(NCH)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req),
      .take (arb_take),
      .any  (arb_any),
      .win  (arb_win)
   );

   cwx_store #(.DEPTH(NCH), .W(CWW)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (st_we),
      .waddr(st_waddr),
      .wdata(st_wdata),
      .re   (st_re),
      .raddr(st_raddr),
      .rdata(st_rdata)
   );

   cwx_seq #(.NCH(NCH), .AW(AW), .CNTW(CNTW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_valid(ld_valid),
      .ld_ch   (ld_ch),
      .ld_addr (ld_addr),
      .ld_cnt  (ld_cnt),
      .ld_ready(ld_ready),
      .arb_any (arb_any),
      .arb_win (arb_win),
      .arb_take(arb_take),
      .st_re   (st_re),
      .st_raddr(st_raddr),
      .st_rdata(st_rdata),
      .st_we   (st_we),
      .st_waddr(st_waddr),
      .st_wdata(st_wdata),
      .mem_req (mem_req),
      .mem_addr(mem_addr),
      .mem_ack (mem_ack),
      .ack_v   (ack_v),
      .done_v  (done_v),
      .cur_ch  (cur_ch)
   );

   assign mem_ch = cur_ch;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_pulse
         assign svc_ack[g] = ack_v  && (cur_ch == CHW'(g));
         assign done_o[g]  = done_v && (cur_ch == CHW'(g));
      end
   endgenerate

endmodule

// File: rtl/cwx_chk.sv
module cwx_chk #(
   parameter int NCH = 8,
   parameter int AW  = 16,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ld_ready,
   input logic           mem_req,
   input logic [AW-1:0]  mem_addr,
   input logic [CHW-1:0] mem_ch,
   input logic           mem_ack,
   input logic [NCH-1:0] svc_ack,
   input logic [NCH-1:0] done_o
);

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_ch)));

   // R5
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(svc_ack));

   // R5
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|svc_ack) |=> !(|svc_ack));

   // R6
   done_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|done_o) |-> ((done_o & svc_ack) == done_o));

   // R9
   busy_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ld_ready);

   // R10
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_req) |-> $past(mem_ack));

endmodule

bind cw_exchange cwx_chk #(.NCH(NCH), .AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ld_ready(ld_ready),
   .mem_req (mem_req),
   .mem_addr(mem_addr),
   .mem_ch  (mem_ch),
   .mem_ack (mem_ack),
   .svc_ack (svc_ack),
   .done_o  (done_o)
);

// File: tb/sim_cw_exchange.sv
module sim_cw_exchange;

   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 8;
   localparam int AW   = 16;
   localparam int CNTW = 16;
   localparam int CHW  = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  req = '0;
   logic            ld_valid = 1'b0;
   logic [CHW-1:0]  ld_ch = '0;
   logic [AW-1:0]   ld_addr = '0;
   logic [CNTW-1:0] ld_cnt = '0;
   logic            ld_ready;
   logic            mem_req;
   logic [AW-1:0]   mem_addr;
   logic [CHW-1:0]  mem_ch;
   logic            mem_ack = 1'b0;
   logic [NCH-1:0]  svc_ack;
   logic [NCH-1:0]  done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int exp_ch[$];
   int exp_addr[$];
   int obs_ch[$];
   int obs_addr[$];
   int ack_cnt[NCH];
   int done_cnt[NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   cw_exchange #(.NCH(NCH), .AW(AW), .CNTW(CNTW)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req),
      .ld_valid(ld_valid), .ld_ch(ld_ch), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
      .ld_ready(ld_ready), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ch(mem_ch), .mem_ack(mem_ack), .svc_ack(svc_ack), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_xfer(input int ch, input int addr);
      exp_ch.push_back(ch);
      exp_addr.push_back(addr);
   endtask

   task automatic load(input int ch, input int addr, input int cnt);
      @(negedge clk);
      while (!ld_ready) @(negedge clk);
      ld_valid = 1'b1;
      ld_ch    = CHW'(ch);
      ld_addr  = AW'(addr);
      ld_cnt   = CNTW'(cnt);
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // memory responder: accepts an outstanding request, records it, acks one cycle
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (rst_n && mem_req) begin
            // R9: no load window while a transfer is outstanding
            chk(ld_ready == 1'b0, "R9 ld_ready during transfer", int'(ld_ready), 0);
            obs_ch.push_back(int'(mem_ch));
            obs_addr.push_back(int'(mem_addr));
            mem_ack = 1'b1;
         end
      end
   end

   // scoreboard monitor: R3 R4 R8 ordering and addresses
   initial begin
      forever begin
         @(negedge clk);
         while (obs_ch.size() > 0) begin
            int oc, oa;
            oc = obs_ch.pop_front();
            oa = obs_addr.pop_front();
            if (exp_ch.size() == 0) begin
               chk(1'b0, "R7 unexpected memory access", oc, -1);
            end else begin
               int ec, ea;
               ec = exp_ch.pop_front();
               ea = exp_addr.pop_front();
               chk(oc == ec, "R8 channel order", oc, ec);
               chk(oa == ea, "R3/R4 access address", oa, ea);
            end
         end
      end
   end

   // pulse counters: R5 R6
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            for (int i = 0; i < NCH; i++) begin
               if (svc_ack[i]) ack_cnt[i]++;
               if (done_o[i])  done_cnt[i]++;
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < NCH; i++) begin
         ack_cnt[i] = 0;
         done_cnt[i] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ld_ready == 1'b1, "R1 ld_ready", int'(ld_ready), 1);
      chk(mem_req == 1'b0,  "R1 mem_req", int'(mem_req), 0);
      chk(svc_ack == '0,    "R1 svc_ack", int'(svc_ack), 0);
      chk(done_o == '0,     "R1 done_o", int'(done_o), 0);

      // R2 loads; channel 2 loaded with count zero is done at once
      load(1, 'h0100, 3);
      load(3, 'h0200, 2);
      load(5, 'h0300, 1);
      load(2, 'h0050, 0);

      // R8 round robin from channel 0, done channels skipped (R7)
      expect_xfer(1, 'h0100);
      expect_xfer(3, 'h0200);
      expect_xfer(5, 'h0300);
      expect_xfer(1, 'h0101);
      expect_xfer(3, 'h0201);
      expect_xfer(1, 'h0102);
      @(negedge clk);
      req = 8'b0010_1110;
      repeat (120) @(negedge clk);
      chk(exp_ch.size() == 0, "R8 all expected transfers seen", exp_ch.size(), 0);
      // R5 per-transfer acknowledge counts
      chk(ack_cnt[1] == 3, "R5 ack count ch1", ack_cnt[1], 3);
      chk(ack_cnt[3] == 2, "R5 ack count ch3", ack_cnt[3], 2);
      chk(ack_cnt[5] == 1, "R5 ack count ch5", ack_cnt[5], 1);
      // R7 done channel ignored
      chk(ack_cnt[2] == 0, "R7 ack count ch2", ack_cnt[2], 0);
      // R6 one completion pulse each, none for zero-count load (R2)
      chk(done_cnt[1] == 1, "R6 done count ch1", done_cnt[1], 1);
      chk(done_cnt[3] == 1, "R6 done count ch3", done_cnt[3], 1);
      chk(done_cnt[5] == 1, "R6 done count ch5", done_cnt[5], 1);
      chk(done_cnt[2] == 0, "R2 no done pulse for zero count", done_cnt[2], 0);

      req = '0;
      repeat (10) @(negedge clk);
      chk(ld_ready == 1'b1, "R9 idle again", int'(ld_ready), 1);

      // R2 reload clears done; R4 address wrap
      load(1, 'hFFFF, 2);
      expect_xfer(1, 'hFFFF);
      expect_xfer(1, 'h0000);
      @(negedge clk);
      req = 8'b0000_0010;
      repeat (60) @(negedge clk);
      req = '0;
      repeat (10) @(negedge clk);
      chk(exp_ch.size() == 0, "R4 wrap transfers seen", exp_ch.size(), 0);
      chk(ack_cnt[1] == 5, "R5 ack count ch1 after reload", ack_cnt[1], 5);
      chk(done_cnt[1] == 2, "R6 done count ch1 after reload", done_cnt[1], 2);
      // R10 nothing left outstanding
      chk(mem_req == 1'b0, "R10 no request pending", int'(mem_req), 0);
      finish_run();
   end

endmodule